// File: doc/BRIEF.md
# Floating-Point Exception Flag and Mask Unit

This block holds the exception state of a floating-point unit. Every cycle the arithmetic datapath and the register-stack logic may each raise one-cycle condition pulses. The block latches these into sticky flags in an 8-bit status word and keeps a 6-bit control word of per-class masks. From the flags and masks it derives a summary bit, which also drives an interrupt request to the software handler.

There are six exception classes: invalid operation, denormal operand, divide by zero, overflow, underflow and inexact result. A separate stack-fault flag records whether an invalid operation came from a register-stack overflow or underflow. An invalid arithmetic operand leaves that flag as it was. A stale 1 from an earlier stack fault can therefore survive.

In the same cycle as a raised condition, the block tells the datapath whether that condition is masked. A masked condition makes the datapath substitute its predefined default result and carry on.

Software writes the control word, reads both words, and clears the status word with a one-cycle command.

Top module: `fpx_status`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 6'h3F (every class masked), the status word reads 8'h00 and the interrupt request is 0.
- R2: A pulse on event bit i sets status bit i on the next clock edge. The bit positions are 0 invalid, 1 denormal, 2 divide by zero, 3 overflow, 4 underflow and 5 inexact.
- R3: Status bits 0 to 6 are sticky. Once set, they stay set until a clear command.
- R4: A stack-fault pulse sets both status bit 0 (invalid) and status bit 6 (stack fault) on the next edge.
- R5: An invalid-operand event (event bit 0) without a stack-fault pulse leaves status bit 6 at its previous value, whether that value is 0 or 1.
- R6: A clear command zeroes status bits 0 to 7 on the next edge. An event or stack-fault pulse in the same cycle as the clear takes priority, and its bits end up set.
- R7: A control-word write takes effect on the next edge and reads back as written. Without a write, the control word holds its value.
- R8: Status bit 7 and the interrupt request both equal the OR, over the six classes, of (flag set AND mask bit 0). They follow mask changes as well as flag changes.
- R9: The default-result output bit i is 1 in the same cycle exactly when class i is raised and its mask bit is 1. For bit 0, a stack-fault pulse counts as raising the invalid class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_evt | input | 6 | Per-class condition pulses from the datapath |
| stk_evt | input | 1 | Register-stack overflow/underflow pulse |
| sts_clr | input | 1 | Clear command for the status word |
| ctl_we | input | 1 | Control-word write enable |
| ctl_wdata | input | 6 | Control-word write data (1 = masked) |
| ctl_rdata | output | 6 | Control-word read data |
| sts_rdata | output | 8 | Status word: flags [5:0], stack fault [6], summary [7] |
| exc_irq | output | 1 | Request to the software handler |
| dflt_res | output | 6 | Per-class "produce default result" indication for this cycle |

## Verification
A lost or stuck flag bit shows in the status readback one edge after the pulse that should have set it. It shows again after the clear that should have dropped it. A wrong mask register shows up in three ways:
- immediately, in the same-cycle default-result bits;
- one edge after a write, in the control readback;
- combinationally, in the summary and interrupt outputs once any flag is set.

A stack-fault bit that is wrongly cleared or wrongly set by an invalid operand shows at bit 6 of the status word on the next edge.

// File: rtl/fpx_pkg.sv
// Shared constants for the floating-point exception unit.
// Bit positions here are architectural: software decodes them.
package fpx_pkg;
    localparam int EXC_N = 6;     // number of exception classes
    localparam int STS_W = 8;     // status word width
    localparam int B_INV = 0;     // invalid operation
    localparam int B_DEN = 1;     // denormal operand
    localparam int B_ZDV = 2;     // divide by zero
    localparam int B_OVF = 3;     // overflow
    localparam int B_UNF = 4;     // underflow
    localparam int B_PRE = 5;     // inexact result
    localparam int B_STK = 6;     // stack fault
    localparam int B_SUM = 7;     // summary
endpackage

// File: rtl/fpx_flag_bank.sv
// Sticky exception flags plus the stack-fault qualifier.
// Assumes: condition pulses last one cycle; a pulse arriving together with
// a clear wins; stack faults fold into the invalid class at INV_BIT.
module fpx_flag_bank
    import fpx_pkg::*;
#(
    parameter int N       = EXC_N,
    parameter int INV_BIT = B_INV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         stk,
    input  logic         clr,
    output logic [N-1:0] flags,
    output logic         stk_flag
);
    logic [N-1:0] evt_eff;

    // Merge the stack-fault pulse into the invalid class.
    always_comb begin
        evt_eff          = evt;
        evt_eff[INV_BIT] = evt[INV_BIT] | stk;
    end

    // One sticky flop per class.
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[g] <= 1'b0;
            else if (evt_eff[g]) flags[g] <= 1'b1;
            else if (clr)        flags[g] <= 1'b0;
        end
    end

    // Stack-fault qualifier: set only by a stack pulse, never by an operand fault.
    always_ff @(posedge clk) begin
        if (!rst_n)   stk_flag <= 1'b0;
        else if (stk) stk_flag <= 1'b1;
        else if (clr) stk_flag <= 1'b0;
    end

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
    a_r4_stack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        stk |=> (flags[INV_BIT] && stk_flag));
    a_r5_stk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk && !clr) |=> (stk_flag == $past(stk_flag)));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0 && !stk) |=> (flags == '0 && !stk_flag));
endmodule

// File: rtl/fpx_mask_reg.sv
// Control word holding one mask bit per exception class.
// Assumes: a write lands on the next edge; reset masks every class.
module fpx_mask_reg
    import fpx_pkg::*;
#(
    parameter int N = EXC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);
    // Load on write, else hold; reset to all masked.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask <= '1;
        else if (we) mask <= wdata;
    end

    a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mask == $past(wdata)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mask));
endmodule

// File: rtl/fpx_report.sv
// Derives the summary/request bit and the same-cycle default-result indication.
// Assumes: flags and mask are registered; evt/stk are this cycle's raw pulses.
module fpx_report
    import fpx_pkg::*;
#(
    parameter int N       = EXC_N,
    parameter int INV_BIT = B_INV
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] evt,
    input  logic         stk,
    output logic         summary,
    output logic [N-1:0] dflt
);
    logic [N-1:0] raised;

    // Summary: any set flag whose class is unmasked.
    always_comb summary = |(flags & ~mask);

    // Default result: a raised class that is masked.
    always_comb begin
        raised          = evt;
        raised[INV_BIT] = evt[INV_BIT] | stk;
        dflt            = raised & mask;
    end
endmodule

// File: rtl/fpx_status.sv
// Top of the floating-point exception unit: flags, masks, summary, request.
// Assumes: a synchronous active-low reset; register access is one cycle wide.
module fpx_status
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXC_N-1:0] exc_evt,
    input  logic             stk_evt,
    input  logic             sts_clr,
    input  logic             ctl_we,
    input  logic [EXC_N-1:0] ctl_wdata,
    output logic [EXC_N-1:0] ctl_rdata,
    output logic [STS_W-1:0] sts_rdata,
    output logic             exc_irq,
    output logic [EXC_N-1:0] dflt_res
);
    logic [EXC_N-1:0] flags;
    logic [EXC_N-1:0] mask;
    logic             stk_flag;
    logic             summary;

    fpx_flag_bank #(.N(EXC_N), .INV_BIT(B_INV)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(exc_evt), .stk(stk_evt), .clr(sts_clr),
        .flags(flags), .stk_flag(stk_flag)
    );

    fpx_mask_reg #(.N(EXC_N)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .mask(mask)
    );

    fpx_report #(.N(EXC_N), .INV_BIT(B_INV)) u_rep (
        .flags(flags), .mask(mask), .evt(exc_evt), .stk(stk_evt),
        .summary(summary), .dflt(dflt_res)
    );

    // Assemble the status word at its architectural positions.
    always_comb begin
        sts_rdata            = '0;
        sts_rdata[EXC_N-1:0] = flags;
        sts_rdata[B_STK]     = stk_flag;
        sts_rdata[B_SUM]     = summary;
    end

    // Control readback and request output.
    always_comb begin
        ctl_rdata = mask;
        exc_irq   = summary;
    end

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exc_irq |-> (sts_rdata[EXC_N-1:0] != '0));
    a_r9_dflt_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((dflt_res & ~ctl_rdata) == '0));
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctl_rdata == '1 && sts_rdata == '0));
endmodule

// File: tb/fpx_status_tb.sv
module fpx_status_tb;
    import fpx_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [EXC_N-1:0] exc_evt = '0;
    logic             stk_evt = 1'b0;
    logic             sts_clr = 1'b0;
    logic             ctl_we = 1'b0;
    logic [EXC_N-1:0] ctl_wdata = '0;
    logic [EXC_N-1:0] ctl_rdata;
    logic [STS_W-1:0] sts_rdata;
    logic             exc_irq;
    logic [EXC_N-1:0] dflt_res;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [EXC_N-1:0] m_flags = '0;
    logic [EXC_N-1:0] m_mask = '1;
    logic             m_stk = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fpx_status u_dut (
        .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .stk_evt(stk_evt),
        .sts_clr(sts_clr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata), .exc_irq(exc_irq),
        .dflt_res(dflt_res)
    );

    function automatic logic f_sum(logic [EXC_N-1:0] f, logic [EXC_N-1:0] m);
        return |(f & ~m);
    endfunction

    function automatic logic [STS_W-1:0] f_status();
        return {f_sum(m_flags, m_mask), m_stk, m_flags};
    endfunction

    function automatic logic [EXC_N-1:0] f_dflt(logic [EXC_N-1:0] e, logic s,
                                                logic [EXC_N-1:0] m);
        logic [EXC_N-1:0] r;
        r = e;
        r[B_INV] = e[B_INV] | s;
        return r & m;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus; check default result now and state after the edge.
    task automatic step(string req, logic [EXC_N-1:0] e, logic s, logic c,
                        logic w, logic [EXC_N-1:0] wd);
        exc_evt = e; stk_evt = s; sts_clr = c; ctl_we = w; ctl_wdata = wd;
        #1;
        chk("R9", {26'd0, dflt_res}, {26'd0, f_dflt(e, s, m_mask)});
        @(posedge clk);
        m_flags = (c ? '0 : m_flags) | e | {{(EXC_N-1){1'b0}}, s};
        m_stk   = (c ? 1'b0 : m_stk) | s;
        if (w) m_mask = wd;
        @(negedge clk);
        exc_evt = '0; stk_evt = 1'b0; sts_clr = 1'b0; ctl_we = 1'b0;
        chk(req, {24'd0, sts_rdata}, {24'd0, f_status()});
        chk("R7", {26'd0, ctl_rdata}, {26'd0, m_mask});
        chk("R8", {31'd0, exc_irq}, {31'd0, f_sum(m_flags, m_mask)});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {26'd0, ctl_rdata}, 32'h3F);
        chk("R1", {24'd0, sts_rdata}, 32'h00);
        chk("R1", {31'd0, exc_irq}, 32'd0);
        // R2 each class in turn, all masked, then R6 clear
        for (int i = 0; i < EXC_N; i++) begin
            step("R2", 6'(1 << i), 1'b0, 1'b0, 1'b0, '0);
            step("R6", '0, 1'b0, 1'b1, 1'b0, '0);
        end
        // R3 sticky over idle cycles
        step("R3", 6'b001010, 1'b0, 1'b0, 1'b0, '0);
        repeat (3) step("R3", '0, 1'b0, 1'b0, 1'b0, '0);
        // R4 stack fault sets invalid and bit 6
        step("R4", '0, 1'b1, 1'b0, 1'b0, '0);
        // R5 invalid operand keeps stale stack-fault bit
        step("R5", 6'b000001, 1'b0, 1'b0, 1'b0, '0);
        step("R6", '0, 1'b0, 1'b1, 1'b0, '0);
        step("R5", 6'b000001, 1'b0, 1'b0, 1'b0, '0);
        // R6 event beats clear in the same cycle
        step("R6", 6'b000100, 1'b1, 1'b1, 1'b0, '0);
        // R8 unmask divide-by-zero -> summary and request follow mask
        step("R8", '0, 1'b0, 1'b0, 1'b1, 6'b111011);
        step("R8", '0, 1'b0, 1'b0, 1'b1, 6'b111111);
        // R9 unmasked class gets no default result
        step("R9", 6'b010000, 1'b0, 1'b0, 1'b1, 6'b101111);
        step("R9", 6'b010000, 1'b1, 1'b0, 1'b0, '0);
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [EXC_N-1:0] e;
            e = 6'($urandom) & 6'($urandom) & 6'($urandom);
            step("R8", e, ($urandom % 8) == 0, ($urandom % 6) == 0,
                 ($urandom % 5) == 0, 6'($urandom));
        end
        done = 1'b1;
        finish_run();
    end
endmodule